// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Controller

This block gathers interrupt requests from three external interrupt pins and two counter input pins. It turns them into four request slots and drives a single interrupt line to a CPU. Each source has its own polarity bit. The polarity bit chooses whether a rising or a falling transition on the pin raises the slot's request. Slot 2 is shared: one select bit chooses whether external pin 2 or counter pin 1 feeds it.

Software uses a small register bus. It sets polarities, the shared-slot select and the per-slot enables. It also reads the pending requests and clears them by writing zeros. A request latches whether or not its enable is set, and only the enable decides whether the request reaches the interrupt line.

The edge detector watches the polarity-adjusted level of each slot. A change of polarity, or of the shared-slot select, can therefore raise a request on its own. The request view on the bus lags the live request register by one cycle, so a read issued straight after a clear still shows the old bit.

Top module: `eint_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq` is 0.
- R2: The slot map is fixed. Slot 0 is external pin 0, slot 1 is external pin 1, slot 2 is the shared slot, and slot 3 is counter pin 0. For each slot, polarity 0 means a low-to-high transition sets the slot's request bit and polarity 1 means a high-to-low transition sets it. The opposite transition sets nothing. The bit is set on the third rising clock edge after the pin changes.
- R3: The polarity-adjusted level of a source is its pin level XOR its polarity bit. Writing a polarity bit while the pin is steady sets the request when this adjusted level goes from 0 to 1. That happens when the pin is low and polarity goes 0 to 1, or when the pin is high and polarity goes 1 to 0.
- R4: Counter pin 0's polarity is bit 6 of address 1, and counter pin 1's polarity is bit 6 of address 2. All other bits of these addresses read 0.
- R5: Bit 0 of address 3 selects the source of slot 2: 0 for external pin 2, 1 for counter pin 1. Transitions on the unselected source do not set slot 2. Changing the select sets slot 2 when the newly selected source's adjusted level is 1 and the old one's was 0.
- R6: A write to address 4 clears each request bit whose write-data bit (bits 3:0) is 0. It leaves bits written with 1 unchanged, and can never set a bit.
- R7: When a hardware set and a software clear hit the same request bit in the same cycle, the bit ends at 1.
- R8: Request bits latch regardless of enable. `irq` is 1 exactly when some bit is 1 both in the request register and in the enable register (address 5, bits 3:0).
- R9: Read data is registered, so the value for the address held in a cycle appears after that cycle's rising edge. A read of address 4 issued in the cycle right after a clear returns the value from before the clear, and the following read returns the cleared value.
- R10: Address 0 bits 2:0 hold the external pin polarities for pins 0, 1 and 2, and read back as written. Address 5 bits 3:0 read back as written. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| ext_pin | input | 3 | Raw external interrupt pins |
| cnt_pin | input | 2 | Raw counter input pins |
| irq | output | 1 | Combined interrupt output |

## Verification
Random pin toggles under both polarities show whether a slot reacts to the right transition and ignores the other one. Polarity writes with the pins held steady show whether adjusted levels are compared, rather than raw pin levels. Toggles on external pin 2 and counter pin 1 under each select value, together with select flips, show whether the shared slot follows only its chosen source. Directed cases time a clear against a hardware set in the same cycle, issue a read straight after a clear, and sweep enables with requests pending, which shows how `irq` is gated.

// File: rtl/eint_pkg.sv
`timescale 1ns/1ps
package eint_pkg;
    localparam int N_EXT       = 3;
    localparam int N_CNT       = 2;
    localparam int N_SLOT      = 4;
    localparam int AW          = 3;
    localparam int DW          = 8;
    localparam int CNT_POL_BIT = 6;
    localparam int SYNC_W      = N_EXT + N_CNT;

    typedef enum logic [AW-1:0] {
        A_EXT_POL = 3'd0,
        A_CNT0    = 3'd1,
        A_CNT1    = 3'd2,
        A_SRC     = 3'd3,
        A_REQ     = 3'd4,
        A_EN      = 3'd5
    } addr_e;

    typedef struct packed {
        logic [N_EXT-1:0] ext_pol;
        logic [N_CNT-1:0] cnt_pol;
        logic             src_sel;
    } cfg_t;

    // polarity-adjusted level of each request slot
    function automatic logic [N_SLOT-1:0] slot_levels(
        input logic [N_EXT-1:0] ext,
        input logic [N_CNT-1:0] cnt,
        input cfg_t             c
    );
        logic [N_EXT-1:0]  e;
        logic [N_CNT-1:0]  k;
        logic [N_SLOT-1:0] s;
        e    = ext ^ c.ext_pol;
        k    = cnt ^ c.cnt_pol;
        s[0] = e[0];
        s[1] = e[1];
        s[2] = c.src_sel ? k[1] : e[2];
        s[3] = k[0];
        return s;
    endfunction
endpackage

// File: rtl/eint_sync.sv
`timescale 1ns/1ps
module eint_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= 1'b0;
                stab_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= d[i];
                stab_q[i] <= meta_q[i];
            end
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/eint_edge.sv
`timescale 1ns/1ps
module eint_edge
    import eint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EXT-1:0]  ext_s,
    input  logic [N_CNT-1:0]  cnt_s,
    input  cfg_t              cfg,
    output logic [N_SLOT-1:0] hw_set
);
    logic [N_SLOT-1:0] lvl;
    logic [N_SLOT-1:0] prev_q;

    assign lvl = slot_levels(ext_s, cnt_s, cfg);

    for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= lvl[i];
        end
        assign hw_set[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/eint_regs.sv
`timescale 1ns/1ps
module eint_regs
    import eint_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic              we,
    input  logic [N_SLOT-1:0] hw_set,
    output cfg_t              cfg,
    output logic [N_SLOT-1:0] req,
    output logic [N_SLOT-1:0] en,
    output logic [DW-1:0]     rdata
);
    cfg_t              cfg_q;
    logic [N_SLOT-1:0] req_q;
    logic [N_SLOT-1:0] view_q;
    logic [N_SLOT-1:0] en_q;
    logic [DW-1:0]     rdata_q;
    logic [N_SLOT-1:0] keep_mask;
    logic [DW-1:0]     rd_mux;
    logic              req_wr;

    wire unused_wdata = ^{wdata[DW-1], wdata[CNT_POL_BIT-1:N_SLOT]};

    assign req_wr    = we && (addr == A_REQ);
    assign keep_mask = req_wr ? wdata[N_SLOT-1:0] : '1;

    always_comb begin
        rd_mux = '0;
        case (addr_e'(addr))
            A_EXT_POL: rd_mux[N_EXT-1:0]   = cfg_q.ext_pol;
            A_CNT0:    rd_mux[CNT_POL_BIT] = cfg_q.cnt_pol[0];
            A_CNT1:    rd_mux[CNT_POL_BIT] = cfg_q.cnt_pol[1];
            A_SRC:     rd_mux[0]           = cfg_q.src_sel;
            A_REQ:     rd_mux[N_SLOT-1:0]  = view_q;
            A_EN:      rd_mux[N_SLOT-1:0]  = en_q;
            default:   rd_mux              = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            en_q    <= '0;
            req_q   <= '0;
            view_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (we) begin
                case (addr_e'(addr))
                    A_EXT_POL: cfg_q.ext_pol    <= wdata[N_EXT-1:0];
                    A_CNT0:    cfg_q.cnt_pol[0] <= wdata[CNT_POL_BIT];
                    A_CNT1:    cfg_q.cnt_pol[1] <= wdata[CNT_POL_BIT];
                    A_SRC:     cfg_q.src_sel    <= wdata[0];
                    A_EN:      en_q             <= wdata[N_SLOT-1:0];
                    default:   ;
                endcase
            end
            // hardware set dominates a same-cycle software clear
            req_q   <= (req_q & keep_mask) | hw_set;
            view_q  <= req_q;
            rdata_q <= rd_mux;
        end
    end

    assign cfg   = cfg_q;
    assign req   = req_q;
    assign en    = en_q;
    assign rdata = rdata_q;
endmodule

// File: rtl/eint_ctrl.sv
`timescale 1ns/1ps
module eint_ctrl
    import eint_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_we,
    output logic [DW-1:0]    bus_rdata,
    input  logic [N_EXT-1:0] ext_pin,
    input  logic [N_CNT-1:0] cnt_pin,
    output logic             irq
);
    logic [SYNC_W-1:0] pins_s;
    cfg_t              cfg;
    logic [N_SLOT-1:0] hw_set;
    logic [N_SLOT-1:0] req_q;
    logic [N_SLOT-1:0] en_q;

    eint_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cnt_pin, ext_pin}),
        .q   (pins_s)
    );

    eint_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .ext_s  (pins_s[N_EXT-1:0]),
        .cnt_s  (pins_s[SYNC_W-1:N_EXT]),
        .cfg    (cfg),
        .hw_set (hw_set)
    );

    eint_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .we     (bus_we),
        .hw_set (hw_set),
        .cfg    (cfg),
        .req    (req_q),
        .en     (en_q),
        .rdata  (bus_rdata)
    );

    assign irq = |(req_q & en_q);
endmodule

// File: rtl/eint_ctrl_chk.sv
`timescale 1ns/1ps
module eint_ctrl_chk
    import eint_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              we,
    input logic [AW-1:0]     addr,
    input logic [DW-1:0]     wdata,
    input logic [N_SLOT-1:0] hw_set,
    input logic [N_SLOT-1:0] req,
    input logic [N_SLOT-1:0] en,
    input logic              irq
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (req == '0 && en == '0 && !irq));

    p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (rst)
        (req & ~$past(req) & ~$past(hw_set)) == '0);

    p_zero_clears_r6: assert property (@(posedge clk) disable iff (rst)
        $past(we && addr == A_REQ) |->
            (req & ~$past(wdata[N_SLOT-1:0]) & ~$past(hw_set)) == '0);

    p_one_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        $past(we && addr == A_REQ) |->
            ($past(req) & $past(wdata[N_SLOT-1:0]) & ~req) == '0);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(hw_set) & ~req) == '0);

    p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq);

    p_irq_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |-> !irq);
endmodule

bind eint_ctrl eint_ctrl_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .we     (bus_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .hw_set (hw_set),
    .req    (req_q),
    .en     (en_q),
    .irq    (irq)
);

// File: tb/eint_ctrl_tb.sv
`timescale 1ns/1ps
module eint_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [2:0] ext_pin = '0;
    logic [1:0] cnt_pin = '0;
    logic       irq;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [2:0] m_epol = '0;
    logic [1:0] m_cpol = '0;
    logic       m_sel = 1'b0;
    logic [3:0] m_en = '0;
    logic [3:0] m_req = '0;
    logic [3:0] m_prev = '0;

    always #2 clk = ~clk;

    eint_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
        .cnt_pin(cnt_pin), .irq(irq)
    );

    function automatic logic [3:0] exp_levels();
        logic [2:0] e;
        logic [1:0] k;
        e = ext_pin ^ m_epol;
        k = cnt_pin ^ m_cpol;
        return {k[0], (m_sel ? k[1] : e[2]), e[1], e[0]};
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return {5'b0, m_epol};
            3'd1:    return {1'b0, m_cpol[0], 6'b0};
            3'd2:    return {1'b0, m_cpol[1], 6'b0};
            3'd3:    return {7'b0, m_sel};
            3'd4:    return {4'b0, m_req};
            3'd5:    return {4'b0, m_en};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        logic [3:0] lv;
        repeat (5) @(negedge clk);
        lv     = exp_levels();
        m_req  = m_req | (lv & ~m_prev);
        m_prev = lv;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            3'd0: m_epol = d[2:0];
            3'd1: m_cpol[0] = d[6];
            3'd2: m_cpol[1] = d[6];
            3'd3: m_sel = d[0];
            3'd4: m_req = m_req & d[3:0];
            3'd5: m_en = d[3:0];
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic check_req(input string tag);
        logic [7:0] r;
        bus_read(3'd4, r);
        check(tag, r, {4'b0, m_req});
        check("R8 irq", {7'b0, irq}, {7'b0, |(m_req & m_en)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'h1c0de));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 and R10: reset values, unused addresses
        for (int a = 0; a < 8; a++) begin
            bus_read(a[2:0], r);
            check(a >= 6 ? "R10 unused addr" : "R1 reset read", r, 8'h00);
        end
        check("R1 irq after reset", {7'b0, irq}, 8'h00);

        // R7: hardware set on slot 0 coincides with a clear write
        @(negedge clk);
        ext_pin[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h00;
        @(negedge clk);
        bus_we = 1'b0;
        settle();
        check_req("R7 set beats clear");

        // R9: stale read right after a clear
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h00;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
        check("R9 read after clear is old", bus_rdata, 8'h01);
        @(negedge clk);
        check("R9 second read is cleared", bus_rdata, 8'h00);
        m_req = '0;

        // R2: falling edge under polarity 0 sets nothing
        ext_pin[0] = 1'b0; settle();
        check_req("R2 opposite edge ignored");

        // R3: pin low steady, polarity 0->1 sets slot 0
        bus_write(3'd0, 8'h01); settle();
        check_req("R3 polarity write sets request");
        bus_write(3'd4, 8'h00); settle();

        // R4: counter polarity bit 6 only
        bus_write(3'd1, 8'hFF); settle();
        bus_read(3'd1, r);
        check("R4 cnt0 ctl readback", r, 8'h40);
        check_req("R4 cnt0 polarity write");

        // R5: shared slot follows selected source
        bus_write(3'd4, 8'h00); settle();
        cnt_pin[1] = 1'b1; settle();
        check_req("R5 unselected counter ignored");
        bus_write(3'd3, 8'h01); settle();
        check_req("R5 select switch");
        ext_pin[2] = 1'b1; settle();
        check_req("R5 unselected ext ignored");

        // R6: writing ones leaves bits, R8 enable gating
        bus_write(3'd4, 8'h0F); settle();
        check_req("R6 write ones keeps");
        bus_write(3'd5, 8'h00); settle();
        check_req("R8 all disabled");
        bus_write(3'd5, 8'h0F); settle();
        check_req("R8 enabled");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom % 7;
            case (op)
                0: begin ext_pin = 3'($urandom); settle(); end
                1: begin cnt_pin = 2'($urandom); settle(); end
                2: begin bus_write(3'd0, 8'($urandom)); settle(); end
                3: begin bus_write(3'(1 + $urandom % 2), 8'($urandom)); settle(); end
                4: begin bus_write(3'd3, 8'($urandom)); settle(); end
                5: begin bus_write(3'd4, 8'($urandom)); settle(); end
                default: begin bus_write(3'd5, 8'($urandom)); settle(); end
            endcase
            check_req("R2 random request");
            if (op >= 2) begin
                for (int a = 0; a < 8; a++) begin
                    bus_read(a[2:0], r);
                    check("R10 readback", r, exp_read(a[2:0]));
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule